// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single management transactions towards an external PHY over a two-wire serial management link. It makes a management clock from the system clock and drives the data line through a pad. For each transaction it takes a PHY address, a register address, write data and a read/write select, together with a one-cycle start pulse. It then produces a complete read or write frame. Each frame opens with a run of ones. A read sends a short command, releases the line and shifts in the PHY's answer. A write sends the whole 32-bit frame and then gives the PHY two more clocks with the line released.

When the frame ends, the block raises a one-cycle done strobe. Read data is presented on its own register, which changes only when a read frame completes. Polling, link negotiation and the meaning of PHY registers are left to the logic that sequences these transactions.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, mdc is 0, mdio_oe is 0, done is 0 and rd_data is 0.
- R2: Every frame begins with PREAMBLE_BITS management clock periods in which mdio_oe is 1 and mdio_o is 1.
- R3: A read (wr_en=0) drives 16 command bits, most significant first, after the opening ones: 1,1, then start 0,1, then opcode 1,0, then the 5-bit PHY address and the 5-bit register address, each MSB first.
- R4: A read then releases the line (mdio_oe=0) for 19 more clock periods, so that a read frame lasts PREAMBLE_BITS+35 management clock periods.
- R5: Read data is taken from mdio_i at the management clock rising edges. The first two released periods (turnaround) are skipped, the next 16 periods give rd_data MSB first, and the final released period is discarded.
- R6: A write (wr_en=1) drives a 32-bit frame, MSB first, after the opening ones: start 0,1, then opcode 0,1, then the PHY address, the register address, turnaround 1,0 and the 16 data bits.
- R7: A write ends with 2 more management clock periods in which mdio_oe=0, for a total of PREAMBLE_BITS+34 periods. Between frames mdc stays 0 and mdio_oe stays 0.
- R8: The management clock has a period of 2*HALF system cycles, with HALF system cycles low followed by HALF high. HALF is the smallest value that keeps mdc at or below MDC_MAX_HZ. A frame of N periods ends with done exactly 2*HALF*N system cycles after the start cycle.
- R9: mdio_o and mdio_oe change only while mdc is low, so they are steady across every mdc rising edge.
- R10: done lasts one system cycle. rd_data changes only in the cycle in which done is raised, and a write leaves it unchanged.
- R11: A start pulse that arrives while a frame is in progress is ignored. The frame in progress keeps its latched addresses and mode, and no extra frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a frame |
| wr_en | input | 1 | 1 selects a write frame, 0 a read frame |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write frame |
| rd_data | output | 16 | Data from the last completed read |
| done | output | 1 | One-cycle strobe at the end of a frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Output enable for the data-line pad |
| mdio_i | input | 1 | Value read back from the data line |

## Verification
The bench builds the block with its default parameters: a 250 MHz system clock, a 2.5 MHz management-clock ceiling and 32 opening ones. This gives HALF=50, so frames last 6700 or 6600 system cycles. At these values the real clock-rate bound is checked, and both mdc half periods and the end-to-end frame length are measured against exact cycle counts. A behavioural PHY answers reads with the turnaround, the data, and a final bit that is the opposite of the data LSB, so a capture window shifted by one bit shows up in rd_data. A second start pulse is issued in the middle of a frame with a changed address, to confirm that it has no effect.

// File: rtl/mdio_pkg.sv
// Package mdio_pkg
// Shared frame constants and frame builders for the management frame master.
// Assumes clause-22 style field widths: 5-bit addresses and 16-bit data.
package mdio_pkg;

    localparam int PHY_W         = 5;
    localparam int REG_W         = 5;
    localparam int DAT_W         = 16;
    localparam int RD_CMD_BITS   = 16;   // driven part of a read after the opening ones
    localparam int RD_RX_BITS    = 19;   // released part: turnaround, data, idle
    localparam int RD_TA_BITS    = 2;    // leading released bits skipped on read
    localparam int WR_FRAME_BITS = 32;   // driven part of a write after the opening ones
    localparam int WR_TAIL_BITS  = 2;    // released clocks after a write

    // Read command: two extra ones, start 01, opcode 10, addresses.
    function automatic logic [RD_CMD_BITS-1:0] read_cmd(
        input logic [PHY_W-1:0] phy,
        input logic [REG_W-1:0] rg
    );
        return {2'b11, 2'b01, 2'b10, phy, rg};
    endfunction

    // Write frame: start 01, opcode 01, addresses, turnaround 10, data.
    function automatic logic [WR_FRAME_BITS-1:0] write_frame(
        input logic [PHY_W-1:0] phy,
        input logic [REG_W-1:0] rg,
        input logic [DAT_W-1:0] dat
    );
        return {2'b01, 2'b01, phy, rg, 2'b10, dat};
    endfunction

endpackage

// File: rtl/mdc_phase_gen.sv
// Module mdc_phase_gen
// Divides the system clock into management clock periods of 2*HALF cycles
// while run is high: HALF cycles low, then HALF cycles high. It marks the
// cycle whose closing edge raises mdc (the sample point) and the cycle whose
// closing edge ends a bit period. Assumes run rises with the counter at zero.
module mdc_phase_gen #(
    parameter int HALF = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_now,
    output logic bit_end
);
    localparam int PERIOD = 2 * HALF;
    localparam int CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] RISE_AT = CW'(HALF - 1);
    localparam logic [CW-1:0] END_AT  = CW'(PERIOD - 1);

    logic [CW-1:0] phase_cnt;

    assign rise_now = run && (phase_cnt == RISE_AT);
    assign bit_end  = run && (phase_cnt == END_AT);

    // Phase counter and registered clock level; both rest at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_cnt <= '0;
            mdc       <= 1'b0;
        end else begin
            phase_cnt <= bit_end ? '0 : phase_cnt + 1'b1;
            if (rise_now)
                mdc <= 1'b1;
            else if (bit_end)
                mdc <= 1'b0;
        end
    end

endmodule

// File: rtl/mdio_bit_seq.sv
// Module mdio_bit_seq
// Frame sequencer: it accepts a request when idle, counts bit periods, shifts
// the command out on the pad registers and shifts the read answer in.
// Assumes bit_end and rise_now come from mdc_phase_gen, which runs on busy.
// The pad registers are updated only at bit boundaries (mdc low).
module mdio_bit_seq
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             wr_en,
    input  logic [PHY_W-1:0] phy_addr,
    input  logic [REG_W-1:0] reg_addr,
    input  logic [DAT_W-1:0] wr_data,
    input  logic             mdio_i,
    input  logic             rise_now,
    input  logic             bit_end,
    output logic             busy,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic             done,
    output logic [DAT_W-1:0] rd_data
);
    localparam int RD_BITS = PRE_BITS + RD_CMD_BITS + RD_RX_BITS;
    localparam int WR_BITS = PRE_BITS + WR_FRAME_BITS + WR_TAIL_BITS;
    localparam int MAXB    = (RD_BITS > WR_BITS) ? RD_BITS : WR_BITS;
    localparam int IW      = $clog2(MAXB + 1);

    localparam logic [IW-1:0] PRE_I      = IW'(PRE_BITS);
    localparam logic [IW-1:0] RD_LAST    = IW'(RD_BITS - 1);
    localparam logic [IW-1:0] WR_LAST    = IW'(WR_BITS - 1);
    localparam logic [IW-1:0] RD_DRV_END = IW'(PRE_BITS + RD_CMD_BITS);
    localparam logic [IW-1:0] WR_DRV_END = IW'(PRE_BITS + WR_FRAME_BITS);
    localparam logic [IW-1:0] CAP_LO     = IW'(PRE_BITS + RD_CMD_BITS + RD_TA_BITS);
    localparam logic [IW-1:0] CAP_HI     = IW'(PRE_BITS + RD_CMD_BITS + RD_TA_BITS + DAT_W - 1);

    logic                     is_wr;
    logic [IW-1:0]            bit_idx;
    logic [WR_FRAME_BITS-1:0] tx_sr;
    logic [DAT_W-1:0]         rx_sr;

    logic          accept, last_bit, in_pre, nxt_oe, nxt_val;
    logic [IW-1:0] nxt_idx, drv_end;

    // Decode of the current bit position and of the next bit's pad value.
    always_comb begin
        accept   = start && !busy;
        last_bit = (bit_idx == (is_wr ? WR_LAST : RD_LAST));
        nxt_idx  = bit_idx + 1'b1;
        drv_end  = is_wr ? WR_DRV_END : RD_DRV_END;
        in_pre   = (bit_idx < PRE_I);
        nxt_oe   = (nxt_idx < drv_end);
        nxt_val  = (nxt_idx < PRE_I) ? 1'b1 : (in_pre ? tx_sr[WR_FRAME_BITS-1] : tx_sr[WR_FRAME_BITS-2]);
    end

    // Frame control: request latch, bit counter, transmit shifter, pad registers, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            is_wr   <= 1'b0;
            bit_idx <= '0;
            tx_sr   <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                is_wr   <= wr_en;
                bit_idx <= '0;
                tx_sr   <= wr_en ? write_frame(phy_addr, reg_addr, wr_data)
                                 : {read_cmd(phy_addr, reg_addr), {(WR_FRAME_BITS-RD_CMD_BITS){1'b0}}};
                mdio_o  <= 1'b1;
                mdio_oe <= 1'b1;
            end else if (busy && bit_end) begin
                if (last_bit) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    mdio_oe <= 1'b0;
                    mdio_o  <= 1'b1;
                end else begin
                    bit_idx <= nxt_idx;
                    if (!in_pre)
                        tx_sr <= {tx_sr[WR_FRAME_BITS-2:0], 1'b0};
                    mdio_oe <= nxt_oe;
                    mdio_o  <= nxt_oe ? nxt_val : 1'b1;
                end
            end
        end
    end

    // Read capture at the mdc rising edge inside the data window; result published at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr   <= '0;
            rd_data <= '0;
        end else begin
            if (busy && !is_wr && rise_now && bit_idx >= CAP_LO && bit_idx <= CAP_HI)
                rx_sr <= {rx_sr[DAT_W-2:0], mdio_i};
            if (busy && !is_wr && bit_end && last_bit)
                rd_data <= rx_sr;
        end
    end

    // R11: the latched mode does not change while a frame runs.
    a_r11_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(is_wr)));

    // R4: past the read command the line stays released.
    a_r4_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !is_wr && bit_idx >= RD_DRV_END) |-> !mdio_oe);

    // R10: done is a single-cycle strobe.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: read data moves only together with done.
    a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rd_data));

endmodule

// File: rtl/mdio_frame_master.sv
// Module mdio_frame_master
// Top of the management frame master: derives the management clock half
// period from the system clock rate and ceiling, and joins the clock divider
// to the frame sequencer. Assumes an external pad joins mdio_o/mdio_oe/mdio_i
// and a pull-up holds the released line high.
module mdio_frame_master #(
    parameter int SYS_CLK_HZ    = 250_000_000,
    parameter int MDC_MAX_HZ    = 2_500_000,
    parameter int PREAMBLE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        wr_en,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        done,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int HALF_RAW = (SYS_CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);
    localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;

    logic busy, rise_now, bit_end;

    // Management clock divider, running only while a frame is active.
    mdc_phase_gen #(
        .HALF (HALF)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .rise_now (rise_now),
        .bit_end  (bit_end)
    );

    // Frame sequencer driving the pad and collecting read data.
    mdio_bit_seq #(
        .PRE_BITS (PREAMBLE_BITS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .wr_en    (wr_en),
        .phy_addr (phy_addr),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .mdio_i   (mdio_i),
        .rise_now (rise_now),
        .bit_end  (bit_end),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rd_data  (rd_data)
    );

    // R9: pad controls hold still while the management clock is high.
    a_r9_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R7: with no frame in progress the clock rests low and the line is released.
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

endmodule

// File: tb/mdio_frame_master_tb.sv
module mdio_frame_master_tb;
    localparam int P    = 32;
    localparam int HALF = 50;          // 250 MHz / (2 * 2.5 MHz)
    localparam int NRD  = P + 35;
    localparam int NWR  = P + 34;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wr_en = 1'b0, mdio_i = 1'b1;
    logic [4:0]  phy_addr = '0, reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic done, mdc, mdio_o, mdio_oe;

    int checks = 0, errors = 0, total_cyc = 0;

    always #2 clk = ~clk;

    mdio_frame_master u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .done(done), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // Behavioural PHY and line monitor.
    logic        tr_oe [0:127];
    logic        tr_v  [0:127];
    int          k = 0, since_rise = 0, per_err = 0, hi_err = 0, stab_err = 0;
    logic        prev_mdc = 1'b0, pre_o = 1'b1, pre_oe = 1'b0;
    logic        phy_rd_mode = 1'b0;
    logic [15:0] phy_data = '0;

    function automatic logic phy_bit(int b);
        int j;
        if (!phy_rd_mode || b < P + 16) return 1'b1;
        j = b - P - 16;
        if (j == 0) return 1'b1;
        if (j == 1) return 1'b0;
        if (j < 18) return phy_data[17 - j];
        return ~phy_data[0];
    endfunction

    always @(negedge clk) begin
        since_rise++;
        if (!prev_mdc && mdc) begin
            if (k < 128) begin
                tr_oe[k] = mdio_oe;
                tr_v[k]  = mdio_o;
            end
            if (mdio_o !== pre_o || mdio_oe !== pre_oe) stab_err++;
            if (k > 0 && since_rise != 2 * HALF) per_err++;
            since_rise = 0;
            k++;
            mdio_i = phy_bit(k);
        end else if (prev_mdc && !mdc) begin
            if (since_rise != HALF) hi_err++;
        end
        pre_o    = mdio_o;
        pre_oe   = mdio_oe;
        prev_mdc = mdc;
    end

    task automatic summary_and_end();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        total_cyc++;
        if (total_cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", total_cyc);
            summary_and_end();
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One frame with full checking; inject issues a start mid-frame with other inputs.
    task automatic run_frame(input logic wr, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] dat, input logic [15:0] exp_rd, input logic inject);
        int cyc, nbits, bad;
        logic seen;
        logic [15:0] cmd16;
        logic [31:0] frm32;
        nbits = wr ? NWR : NRD;
        cmd16 = {2'b11, 2'b01, 2'b10, pa, ra};
        frm32 = {2'b01, 2'b01, pa, ra, 2'b10, dat};
        @(negedge clk);
        phy_rd_mode = !wr; phy_data = dat; mdio_i = 1'b1;
        wr_en = wr; phy_addr = pa; reg_addr = ra; wr_data = dat; start = 1'b1;
        per_err = 0; hi_err = 0; stab_err = 0;
        @(posedge clk); #1;
        start = 1'b0; k = 0; since_rise = 0;
        cyc = 0; seen = 1'b0;
        while (!seen && cyc < 20000) begin
            @(posedge clk); #1;
            cyc++;
            if (inject && cyc == 300) begin
                start = 1'b1; phy_addr = ~pa; reg_addr = ~ra; wr_en = ~wr;
            end else if (inject && cyc == 301) begin
                start = 1'b0; phy_addr = pa; reg_addr = ra; wr_en = wr;
            end
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        chk(seen && cyc == 2 * HALF * nbits, "R8 frame length in cycles", cyc, 2 * HALF * nbits);
        chk(k == nbits, wr ? "R7 write clock periods" : "R4 read clock periods", k, nbits);
        bad = 0;
        for (int i = 0; i < P; i++) if (tr_oe[i] !== 1'b1 || tr_v[i] !== 1'b1) bad++;
        chk(bad == 0, "R2 opening ones", bad, 0);
        bad = 0;
        if (wr) begin
            for (int i = 0; i < 32; i++) if (tr_oe[P+i] !== 1'b1 || tr_v[P+i] !== frm32[31-i]) bad++;
            chk(bad == 0, inject ? "R11 write frame bits" : "R6 write frame bits", bad, 0);
            bad = 0;
            for (int i = 32; i < 34; i++) if (tr_oe[P+i] !== 1'b0) bad++;
            chk(bad == 0, "R7 released tail", bad, 0);
        end else begin
            for (int i = 0; i < 16; i++) if (tr_oe[P+i] !== 1'b1 || tr_v[P+i] !== cmd16[15-i]) bad++;
            chk(bad == 0, inject ? "R11 read command bits" : "R3 read command bits", bad, 0);
            bad = 0;
            for (int i = 16; i < 35; i++) if (tr_oe[P+i] !== 1'b0) bad++;
            chk(bad == 0, "R4 line released", bad, 0);
        end
        chk(rd_data === exp_rd, wr ? "R10 rd_data kept over write" : "R5 read data", rd_data, exp_rd);
        chk(per_err == 0 && hi_err == 0, "R8 mdc period and high time", per_err + hi_err, 0);
        chk(stab_err == 0, "R9 pad steady across rise", stab_err, 0);
        @(negedge clk);
        chk(done === 1'b0, "R10 done one cycle", done, 0);
        if (inject) begin
            repeat (300) @(negedge clk);
            chk(k == nbits && mdc === 1'b0, "R11 no extra frame", k, nbits);
        end
        repeat (20) @(negedge clk);
        chk(mdc === 1'b0 && mdio_oe === 1'b0, "R7 idle line", {mdc, mdio_oe}, 0);
        chk(rd_data === exp_rd, "R10 rd_data stable until next start", rd_data, exp_rd);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mdc === 1'b0 && mdio_oe === 1'b0 && done === 1'b0 && rd_data === 16'h0,
            "R1 reset state", {mdc, mdio_oe, done, rd_data}, 0);
    endtask

    initial begin
        test_reset();
        run_frame(1'b0, 5'h01, 5'h02, 16'hA5C3, 16'hA5C3, 1'b0);
        run_frame(1'b0, 5'h1F, 5'h00, 16'h0001, 16'h0001, 1'b0);
        run_frame(1'b1, 5'h15, 5'h0A, 16'h8E71, 16'h0001, 1'b0);
        run_frame(1'b0, 5'h0A, 5'h1F, 16'hFFFE, 16'hFFFE, 1'b0);
        run_frame(1'b1, 5'h00, 5'h11, 16'h0000, 16'hFFFE, 1'b1);
        run_frame(1'b0, 5'h12, 5'h05, 16'h3C5A, 16'h3C5A, 1'b1);
        summary_and_end();
    end
endmodule